// File: doc/BRIEF.md
# Power Mode and Clock Enable Controller

This block chooses the power mode of a media processor and turns that mode into clock enables. Software writes it through a single write port with a valid/ready handshake. It can select one of three modes: full speed, reduced CPU rate, or sleep. It can also store a mask of module clocks that keep running through sleep, a reduced CPU rate code, and an option that slows the outgoing PCI clock while the system sleeps. Clock gating is modelled as synchronous enables. All timing counts cycles of the reference clock `clk`, which stands for the 27 MHz crystal.

The block is built around four states. `ST_RUN` is normal operation in full-speed or saving mode. `ST_QUIESCE` holds the PCI bus quiet while clocks still run. `ST_SLEEP` cuts every clock except the retained ones. `ST_RESTORE` brings the clocks back while the bus stays quiet. The transitions are:
- RUN→QUIESCE on an accepted sleep write.
- QUIESCE→SLEEP after a fixed hold count.
- SLEEP→RESTORE when the registered wake flag is set.
- RESTORE→RUN after one cycle.

A free-running divider produces a divide-by-16 PCI clock. A select flag marks when the outgoing PCI clock should use it. That flag only changes while the divided clock is low.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset: `cur_mode` is 0 (normal), every `mod_clk_en` bit is 1, `cpu_clk_en`=1, `cpu_clk_sel`=0, `pci_quiesce`=0, `wr_ready`=1, `pci_slow_sel`=0. The retain mask, rate code and slow option all reset to 0.
- R2: In normal mode (mode code 2'b00), all module enables are 1 and `cpu_clk_sel` is 0, which means full CPU rate.
- R3: A write to address 2 stores `wr_data[2:0]` as the CPU rate code. In saving mode (code 2'b01), `cpu_clk_sel` equals that code and all module enables stay 1.
- R4: A write to address 0 takes the mode from `wr_data[1:0]` and the PCI-slow option from `wr_data[2]`. A mode code of 2'b11 leaves the mode and the option unchanged. A write to address 3 has no effect. `cur_mode` is never 2'b11.
- R5: When a sleep write (2'b10) is accepted at an edge, `pci_quiesce` is 1 from that edge. Clocks stay as they were for 4 more cycles. From the 4th following edge, `mod_clk_en` equals the retain mask (written at address 1), `cpu_clk_en`=0 and `cpu_clk_sel`=0.
- R6: `wr_ready` is 1 only in `ST_RUN`. Writes offered while `wr_ready` is 0 have no effect.
- R7: While asleep, any 1 on `wake_evt` is registered at one edge. At the next edge, all clocks come back, and the mode and rate that were active before sleep are restored. One edge later, `pci_quiesce` drops.
- R8: `pci_div_clk` toggles every 8 cycles from reset, which gives a 50% duty cycle at the reference clock divided by 16.
- R9: `pci_slow_sel` follows (asleep AND slow option) but is updated only at edges where `pci_div_clk` was 0.
- R10: `pci_quiesce` is 1 whenever `cpu_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (crystal rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | 2 | 0 mode, 1 retain mask, 2 CPU rate, 3 unused |
| wr_data | input | NUM_MOD | Write data |
| wake_evt | input | WAKE_W | Wake event lines |
| mod_clk_en | output | NUM_MOD | Per-module clock enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_clk_sel | output | CPU_SEL_W | CPU rate code, 0 = full rate |
| pci_quiesce | output | 1 | Block PCI traffic in both directions |
| pci_div_clk | output | 1 | Reference clock divided by 16 |
| pci_slow_sel | output | 1 | Outgoing PCI clock uses the divided clock |
| cur_mode | output | 2 | Current mode code |

## Verification
A wrong state or a wrong hold count shows at the ports within one cycle. It appears as early or late changes of `pci_quiesce`, `wr_ready` or the enables, compared with the exact edges given in R5 and R7. A lost pre-sleep mode shows up as a wrong `cur_mode` or `cpu_clk_sel` on the first cycle of `ST_RESTORE`. A wrong divider count or a select update taken in the high phase shows up at the first toggle or the first slow request. Each of these is compared with a behavioural model on every cycle.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_SAVING = 2'b01,
        MODE_SLEEP  = 2'b10,
        MODE_RSVD   = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_QUIESCE,
        ST_SLEEP,
        ST_RESTORE
    } pstate_e;

    localparam logic [1:0] ADDR_MODE   = 2'd0;
    localparam logic [1:0] ADDR_RETAIN = 2'd1;
    localparam logic [1:0] ADDR_CPU    = 2'd2;
endpackage

// File: rtl/pcg_cfg.sv
module pcg_cfg
    import pcg_pkg::*;
#(
    parameter int NUM_MOD   = 8,
    parameter int CPU_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [NUM_MOD-1:0]   wr_data,
    output logic [NUM_MOD-1:0]   retain_mask,
    output logic [CPU_SEL_W-1:0] cpu_rate,
    output logic                 pci_slow_en,
    output logic                 mode_wr,
    output pmode_e               mode_val
);
    logic mode_legal;

    assign mode_legal = (wr_data[1:0] != MODE_RSVD);
    assign mode_wr    = wr_en && (wr_addr == ADDR_MODE) && mode_legal;
    assign mode_val   = pmode_e'(wr_data[1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            retain_mask <= '0;
            cpu_rate    <= '0;
            pci_slow_en <= 1'b0;
        end else begin
            if (mode_wr)
                pci_slow_en <= wr_data[2];
            if (wr_en && wr_addr == ADDR_RETAIN)
                retain_mask <= wr_data;
            if (wr_en && wr_addr == ADDR_CPU)
                cpu_rate <= wr_data[CPU_SEL_W-1:0];
        end
    end
endmodule

// File: rtl/pcg_fsm.sv
module pcg_fsm
    import pcg_pkg::*;
#(
    parameter int WAKE_W      = 3,
    parameter int QUIESCE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  pmode_e            mode_val,
    input  logic [WAKE_W-1:0] wake_evt,
    output pmode_e            cur_mode,
    output pmode_e            run_mode,
    output logic              wr_ready,
    output logic              cpu_clk_en,
    output logic              pci_quiesce,
    output logic              asleep
);
    localparam int QC_W = $clog2(QUIESCE_CYC + 1);

    pstate_e          state_q, state_d;
    pmode_e           mode_q, mode_d, prev_q, prev_d;
    logic [QC_W-1:0]  qcnt_q, qcnt_d;
    logic             wake_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        prev_d  = prev_q;
        qcnt_d  = qcnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (mode_wr) begin
                    if (mode_val == MODE_SLEEP) begin
                        prev_d  = mode_q;
                        mode_d  = MODE_SLEEP;
                        qcnt_d  = '0;
                        state_d = ST_QUIESCE;
                    end else begin
                        mode_d = mode_val;
                    end
                end
            end
            ST_QUIESCE: begin
                if (qcnt_q == QC_W'(QUIESCE_CYC - 1))
                    state_d = ST_SLEEP;
                else
                    qcnt_d = qcnt_q + 1'b1;
            end
            ST_SLEEP: begin
                if (wake_q) begin
                    mode_d  = prev_q;
                    state_d = ST_RESTORE;
                end
            end
            ST_RESTORE: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            mode_q  <= MODE_NORMAL;
            prev_q  <= MODE_NORMAL;
            qcnt_q  <= '0;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            prev_q  <= prev_d;
            qcnt_q  <= qcnt_d;
            wake_q  <= |wake_evt;
        end
    end

    // outputs
    always_comb begin
        asleep      = (state_q == ST_SLEEP);
        cpu_clk_en  = !asleep;
        pci_quiesce = (state_q != ST_RUN);
        wr_ready    = (state_q == ST_RUN);
        cur_mode    = mode_q;
        run_mode    = (mode_q == MODE_SLEEP) ? prev_q : mode_q;
    end
endmodule

// File: rtl/pcg_pci_div.sv
module pcg_pci_div #(
    parameter int PCI_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_req,
    output logic pci_div_clk,
    output logic pci_slow_sel
);
    localparam int HALF = PCI_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            pci_div_clk  <= 1'b0;
            pci_slow_sel <= 1'b0;
        end else begin
            if (cnt_q == CW'(HALF - 1)) begin
                cnt_q       <= '0;
                pci_div_clk <= ~pci_div_clk;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (!pci_div_clk)
                pci_slow_sel <= slow_req;
        end
    end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pcg_pkg::*;
#(
    parameter int NUM_MOD     = 8,
    parameter int CPU_SEL_W   = 3,
    parameter int WAKE_W      = 3,
    parameter int QUIESCE_CYC = 4,
    parameter int PCI_DIV     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [1:0]           wr_addr,
    input  logic [NUM_MOD-1:0]   wr_data,
    input  logic [WAKE_W-1:0]    wake_evt,
    output logic [NUM_MOD-1:0]   mod_clk_en,
    output logic                 cpu_clk_en,
    output logic [CPU_SEL_W-1:0] cpu_clk_sel,
    output logic                 pci_quiesce,
    output logic                 pci_div_clk,
    output logic                 pci_slow_sel,
    output logic [1:0]           cur_mode
);
    logic                 wr_en;
    logic [NUM_MOD-1:0]   retain_mask;
    logic [CPU_SEL_W-1:0] cpu_rate;
    logic                 pci_slow_en;
    logic                 mode_wr;
    pmode_e               mode_val;
    pmode_e               mode_cur;
    pmode_e               run_mode;
    logic                 asleep;

    assign wr_en = wr_valid && wr_ready;

    pcg_cfg #(.NUM_MOD(NUM_MOD), .CPU_SEL_W(CPU_SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .retain_mask(retain_mask), .cpu_rate(cpu_rate),
        .pci_slow_en(pci_slow_en), .mode_wr(mode_wr), .mode_val(mode_val)
    );

    pcg_fsm #(.WAKE_W(WAKE_W), .QUIESCE_CYC(QUIESCE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
        .wake_evt(wake_evt), .cur_mode(mode_cur), .run_mode(run_mode),
        .wr_ready(wr_ready), .cpu_clk_en(cpu_clk_en),
        .pci_quiesce(pci_quiesce), .asleep(asleep)
    );

    pcg_pci_div #(.PCI_DIV(PCI_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .slow_req(asleep && pci_slow_en),
        .pci_div_clk(pci_div_clk), .pci_slow_sel(pci_slow_sel)
    );

    // per-module gate: retained clocks keep their own enable during sleep
    for (genvar g = 0; g < NUM_MOD; g++) begin : g_gate
        assign mod_clk_en[g] = asleep ? retain_mask[g] : 1'b1;
    end

    assign cpu_clk_sel = (cpu_clk_en && run_mode == MODE_SAVING) ? cpu_rate : '0;
    assign cur_mode    = mode_cur;
endmodule

// File: rtl/pcg_chk.sv
module pcg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_clk_en,
    input logic       pci_quiesce,
    input logic       wr_ready,
    input logic       pci_div_clk,
    input logic       pci_slow_sel,
    input logic [1:0] cur_mode
);
    // R10
    cpu_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> pci_quiesce);

    // R5
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_en) |-> ($past(pci_quiesce, 1) && $past(pci_quiesce, 2)
                               && $past(pci_quiesce, 3) && $past(pci_quiesce, 4)));

    // R7
    restore_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_quiesce) |-> (cpu_clk_en && $past(cpu_clk_en)));

    // R4
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mode != 2'b11);

    // R9
    slow_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pci_slow_sel) |-> !$past(pci_div_clk));

    // R6
    ready_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !pci_quiesce);
endmodule

bind pwr_clk_ctrl pcg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_clk_en(cpu_clk_en),
    .pci_quiesce(pci_quiesce), .wr_ready(wr_ready),
    .pci_div_clk(pci_div_clk), .pci_slow_sel(pci_slow_sel),
    .cur_mode(cur_mode)
);

// File: tb/sim_pwr_clk_ctrl.sv
module sim_pwr_clk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] wake_evt = 3'd0;
    logic [7:0] mod_clk_en;
    logic       cpu_clk_en;
    logic [2:0] cpu_clk_sel;
    logic       pci_quiesce;
    logic       pci_div_clk;
    logic       pci_slow_sel;
    logic [1:0] cur_mode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwr_clk_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wake_evt(wake_evt),
        .mod_clk_en(mod_clk_en), .cpu_clk_en(cpu_clk_en),
        .cpu_clk_sel(cpu_clk_sel), .pci_quiesce(pci_quiesce),
        .pci_div_clk(pci_div_clk), .pci_slow_sel(pci_slow_sel),
        .cur_mode(cur_mode)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 run, 1 quiet hold, 2 asleep, 3 restoring
    int       m_ph, m_mode, m_prev, m_rate, m_qc, m_dcnt;
    bit       m_slow, m_div, m_sel, m_wq;
    bit [7:0] m_mask;

    always @(posedge clk) begin : model
        int oph;
        bit od, ow;
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_prev = 0; m_rate = 0; m_qc = 0; m_dcnt = 0;
            m_slow = 0; m_div = 0; m_sel = 0; m_wq = 0; m_mask = 0;
        end else begin
            oph = m_ph; od = m_div; ow = m_wq;
            if (!od) m_sel = (oph == 2) && m_slow;
            if (m_dcnt == 7) begin m_dcnt = 0; m_div = !m_div; end
            else m_dcnt++;
            m_wq = |wake_evt;
            case (oph)
                0: if (wr_valid) begin
                    case (wr_addr)
                        2'd0: if (wr_data[1:0] != 2'b11) begin
                            m_slow = wr_data[2];
                            if (wr_data[1:0] == 2'b10) begin
                                m_prev = m_mode; m_mode = 2; m_ph = 1; m_qc = 0;
                            end else m_mode = int'(wr_data[1:0]);
                        end
                        2'd1: m_mask = wr_data;
                        2'd2: m_rate = int'(wr_data[2:0]);
                        default: ;
                    endcase
                end
                1: if (m_qc == 3) m_ph = 2; else m_qc++;
                2: if (ow) begin m_ph = 3; m_mode = m_prev; end
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin : compare
        int eff, esel;
        bit [7:0] emask;
        if (rst_n) begin
            eff   = (m_mode == 2) ? m_prev : m_mode;
            esel  = (m_ph != 2 && eff == 1) ? m_rate : 0;
            emask = (m_ph == 2) ? m_mask : 8'hFF;
            check(mod_clk_en == emask, "R5 mod_clk_en", int'(mod_clk_en), int'(emask));
            check(int'(cpu_clk_sel) == esel, "R3 cpu_clk_sel", int'(cpu_clk_sel), esel);
            check(cpu_clk_en == (m_ph != 2), "R7 cpu_clk_en", int'(cpu_clk_en), int'(m_ph != 2));
            check(int'(cur_mode) == m_mode, "R4 cur_mode", int'(cur_mode), m_mode);
            check(pci_quiesce == (m_ph != 0), "R10 pci_quiesce", int'(pci_quiesce), int'(m_ph != 0));
            check(wr_ready == (m_ph == 0), "R6 wr_ready", int'(wr_ready), int'(m_ph == 0));
            check(pci_div_clk == m_div, "R8 pci_div_clk", int'(pci_div_clk), int'(m_div));
            check(pci_slow_sel == m_sel, "R9 pci_slow_sel", int'(pci_slow_sel), int'(m_sel));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wake(input logic [2:0] w);
        @(negedge clk);
        wake_evt = w;
        @(negedge clk);
        wake_evt = 3'd0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cur_mode == 2'd0 && mod_clk_en == 8'hFF && cpu_clk_en && cpu_clk_sel == 3'd0
              && !pci_quiesce && wr_ready && !pci_slow_sel, "R1 reset state",
              int'({cur_mode, mod_clk_en}), 32'h0FF);
        wr(2'd2, 8'd5);
        wr(2'd0, 8'd1);              // saving
        idle(3);
        wr(2'd0, 8'd3);              // reserved code, R4
        wr(2'd3, 8'hFF);             // unused address, R4
        wr(2'd1, 8'hA5);
        wr(2'd0, 8'h06);             // sleep with slow PCI clock
        idle(40);
        wr(2'd0, 8'd0);              // offered while asleep, R6
        wake(3'b010);
        idle(4);
        // R7 pre-sleep mode and rate restored
        check(cur_mode == 2'd1 && cpu_clk_sel == 3'd5, "R7 restored saving",
              int'({cur_mode, cpu_clk_sel}), 32'h0D);
        idle(20);
        wr(2'd0, 8'd0);
        idle(1);
        // R2 normal mode
        check(cur_mode == 2'd0 && cpu_clk_sel == 3'd0 && mod_clk_en == 8'hFF,
              "R2 normal mode", int'({cur_mode, cpu_clk_sel}), 0);
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'd2);
        idle(10);
        wake(3'b100);
        idle(20);
        for (int i = 0; i < 8; i++) begin
            wr(2'd1, 8'(i * 37));
            wr(2'd2, 8'(i));
            wr(2'd0, 8'(i & 1));
            wr(2'd0, 8'(2 | ((i & 1) << 2)));
            idle(i + 2);
            wake(3'(1 << (i % 3)));
            idle(5 + i * 3);
        end
        idle(5);
        finish_run();
    end
endmodule